// File: doc/BRIEF.md
# Digit-Serial Distributed-Arithmetic FIR Filter

This block is a single-rate FIR filter with fixed coefficients. It forms each output with no multiplier. The taps are held in a shift-register delay line. For every bit position, a lookup table returns the sum of the coefficients whose taps have a one at that position. A shift-accumulate stage then weights each table output by its bit significance and adds it in. The lookup tables are computed from the coefficient parameter at elaboration.

The parameter `BITS_PER_CLK` sets how many bit positions are processed in each clock. There is one lookup table for each of those positions. A value of 1 gives a serial engine that is small and needs one clock per sample bit. A value equal to the sample width gives a fully parallel engine that produces one result per clock. Values in between give semi-parallel timing. The number of taps does not change the cycle count.

When `SYMMETRIC` is set, a pre-adder sums each pair of mirrored taps before the lookup. This halves the table address width and adds one bit to the word that is processed. The sample source presents a word with `in_valid`. The block takes one sample per clocks-per-output period and flags each result with a one-cycle `out_valid` pulse.

Top module: `fir_da_top`

## Requirements
- R1: Reset is synchronous and active low.
  - After reset, `out_valid` is 0 and `out_result` is 0.
  - Every tap of the delay line is zero, so the first result after reset equals c0 times the first sample.
- R2: `out_result` equals the sum over k of c[k]·x[n−k], computed exactly in two's complement at full width.
  - x[n] is the newest accepted sample.
  - Coefficient c[k] is the signed `COEF_W`-bit field at bits [k·COEF_W +: COEF_W] of `COEFS`.
- R3: `out_valid` is a one-cycle pulse. It is high after the CPO-th rising edge that follows the edge where the sample was accepted. CPO is the clocks-per-output count.
- R4: A sample is accepted at a rising edge where `in_valid` is high and the block is either idle or in the cycle of its final digit.
  - If `in_valid` is held high, the block accepts one sample and emits one result every CPO cycles.
  - The last digit of one sample and the acceptance of the next can fall in the same cycle.
- R5: `in_valid` in a cycle that is not the final-digit cycle of a busy block is ignored. The delay line does not shift and the sample never reaches a result.
- R6: CPO equals ceil((`DATA_W` + `SYMMETRIC`) / `BITS_PER_CLK`). With one bit per clock this takes `DATA_W` cycles. With all bits per clock it takes one cycle.
- R7: Samples are two's complement. The most negative and most positive sample values give exact results because the top bit slice is subtracted.
- R8: With `SYMMETRIC`=1, taps k and `TAPS`−1−k are summed by a pre-adder that is one bit wider than the sample.
  - Both taps of the pair use coefficient c[k].
  - Only the first `TAPS`/2 coefficients are read, and `TAPS` must be even.
- R9: When the processed width is not a multiple of `BITS_PER_CLK`, the word is sign-extended to the next multiple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | DATA_W | Two's-complement input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | OUT_W | Signed filter output, full precision |

## Verification
When `in_valid` is held high, one sample's final digit is accumulated and its result is registered in the same cycle as the next sample is loaded into the delay line. On that edge the accumulator must clear for the new word and must not lose the last partial sum of the old one. The bench provokes this by holding `in_valid` high for many cycles with a different sample in each cycle. Four instances run side by side, covering serial, fully parallel, padded semi-parallel and symmetric configurations. Each result is compared with a reference convolution of exactly the samples a bench-side acceptance model says were taken, and each latency is compared with that instance's CPO.

// File: rtl/fir_da_pkg.sv
// Shared width helpers for the distributed-arithmetic FIR.
// Assumes all arguments are positive; used by the RTL and by the bench.
package fir_da_pkg;

    // Integer ceiling division.
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Width of one lookup entry: sum of na signed cw-bit coefficients.
    function automatic int lut_w(input int cw, input int na);
        return cw + $clog2(na) + 1;
    endfunction

    // Processed word width after the optional pre-adder and padding to a digit multiple.
    function automatic int pad_w(input int dw, input int symm, input int b);
        return cdiv(dw + symm, b) * b;
    endfunction

    // Full-precision output width.
    function automatic int out_w(input int dw, input int cw, input int taps,
                                 input int symm, input int b);
        int na;
        na = (symm != 0) ? taps / 2 : taps;
        return lut_w(cw, na) + pad_w(dw, symm, b) + 1;
    endfunction

endpackage

// File: rtl/fir_da_rom.sv
// Coefficient-sum lookup for one bit position.
// Entry a holds the sum of coefficients c[k] for every k whose bit is set in a.
// The table is computed from COEFS at elaboration; only the low NA coefficients are read.
module fir_da_rom #(
    parameter int TAPS = 4,
    parameter int NA   = 4,
    parameter int CW   = 8,
    parameter int LW   = 11,
    parameter logic [TAPS*CW-1:0] COEFS = '0
) (
    input  logic [NA-1:0]          addr_i,
    output logic signed [LW-1:0]   val_o
);

    localparam int DEPTH = 2 ** NA;

    // Sum of the coefficients selected by address a.
    function automatic logic signed [LW-1:0] entry(input int a);
        logic signed [LW-1:0] s;
        logic signed [CW-1:0] c;
        s = '0;
        for (int k = 0; k < NA; k++) begin
            c = COEFS[k*CW +: CW];
            if (((a >> k) & 1) == 1)
                s = s + {{(LW-CW){c[CW-1]}}, c};
        end
        return s;
    endfunction

    logic signed [LW-1:0] tbl [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        assign tbl[a] = entry(a);
    end

    // Table read.
    assign val_o = tbl[addr_i];

endmodule

// File: rtl/fir_da_line.sv
// Delay line, optional mirrored-tap pre-adder and per-tap digit shifters.
// On load the taps shift and the processed words are captured from the new tap contents.
// On each step the processed words shift right by B bits, arithmetically.
// Assumes TAPS is even when SYMM is set, and PW >= DW + SYMM.
module fir_da_line #(
    parameter int TAPS = 4,
    parameter int DW   = 8,
    parameter int NA   = 4,
    parameter int PW   = 8,
    parameter int B    = 1,
    parameter int SYMM = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    step_i,
    input  logic [DW-1:0]           sample_i,
    output logic [B-1:0][NA-1:0]    dig_o
);

    logic signed [DW-1:0] x_q [TAPS];
    logic signed [DW-1:0] x_n [TAPS];
    logic signed [PW-1:0] w_q [NA];
    logic signed [PW-1:0] w_n [NA];

    // Next delay-line contents when a sample is accepted.
    always_comb begin
        x_n[0] = sample_i;
        for (int k = 1; k < TAPS; k++) x_n[k] = x_q[k-1];
    end

    // Words fed to the digit engine: a single tap, or a mirrored pair summed one bit wider.
    always_comb begin
        for (int k = 0; k < NA; k++) begin
            if (SYMM != 0) w_n[k] = PW'(x_n[k]) + PW'(x_n[TAPS-1-k]);
            else           w_n[k] = PW'(x_n[k]);
        end
    end

    // Tap and digit-word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) x_q[k] <= '0;
            for (int k = 0; k < NA; k++)   w_q[k] <= '0;
        end else if (load_i) begin
            for (int k = 0; k < TAPS; k++) x_q[k] <= x_n[k];
            for (int k = 0; k < NA; k++)   w_q[k] <= w_n[k];
        end else if (step_i) begin
            for (int k = 0; k < NA; k++)   w_q[k] <= w_q[k] >>> B;
        end
    end

    // Lookup addresses: bit j of every word forms the address of table j.
    always_comb begin
        for (int j = 0; j < B; j++)
            for (int k = 0; k < NA; k++)
                dig_o[j][k] = w_q[k][j];
    end

    AST_TAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (x_q[0] == $past(sample_i)));                          // R2
    AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(x_q[0]));                                     // R5

endmodule

// File: rtl/fir_da_acc.sv
// Digit sequencer and shift-accumulate stage.
// Each busy cycle adds the B lookup outputs, each weighted by its bit position,
// scaled by the digit index. The sign slice of the last digit is subtracted.
// A new sample may load in the final-digit cycle; the accumulator clears on load or on finish.
module fir_da_acc #(
    parameter int B   = 1,
    parameter int LW  = 11,
    parameter int CPO = 8,
    parameter int OW  = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid_i,
    input  logic [B*LW-1:0]         lut_i,
    output logic                    load_o,
    output logic                    step_o,
    output logic                    out_valid_o,
    output logic signed [OW-1:0]    out_result_o
);

    localparam int DCW = (CPO > 1) ? $clog2(CPO) : 1;

    logic                  busy_q;
    logic [DCW-1:0]        d_q;
    logic signed [OW-1:0]  acc_q;
    logic                  last;
    logic signed [LW-1:0]  lv;
    logic signed [OW-1:0]  wv;
    logic signed [OW-1:0]  part;
    logic signed [OW-1:0]  term;
    logic signed [OW-1:0]  nxt;

    // Final-digit flag and the acceptance rule.
    assign last   = busy_q && (d_q == DCW'(CPO - 1));
    assign load_o = in_valid_i && (!busy_q || last);
    assign step_o = busy_q;

    // Weighted sum of this digit's lookup outputs, sign slice negated.
    always_comb begin
        part = '0;
        lv   = '0;
        wv   = '0;
        for (int j = 0; j < B; j++) begin
            lv = lut_i[j*LW +: LW];
            wv = OW'(lv) <<< j;
            if (last && (j == B - 1)) part = part - wv;
            else                      part = part + wv;
        end
        term = part <<< (int'(d_q) * B);
        nxt  = acc_q + term;
    end

    // Sequencer, accumulator and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q       <= 1'b0;
            d_q          <= '0;
            acc_q        <= '0;
            out_valid_o  <= 1'b0;
            out_result_o <= '0;
        end else begin
            out_valid_o <= last;
            if (last) out_result_o <= nxt;
            if (load_o) begin
                busy_q <= 1'b1;
                d_q    <= '0;
                acc_q  <= '0;
            end else if (last) begin
                busy_q <= 1'b0;
                d_q    <= '0;
                acc_q  <= '0;
            end else if (busy_q) begin
                d_q    <= d_q + 1'b1;
                acc_q  <= nxt;
            end
        end
    end

    AST_OUT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(busy_q));                                   // R3
    AST_START_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> (d_q == '0));                                   // R3
    AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$past(load_o) && !$past(last))
            |-> (d_q == $past(d_q) + 1'b1));                              // R6

endmodule

// File: rtl/fir_da_top.sv
// Digit-serial distributed-arithmetic FIR filter, fixed coefficients.
// BITS_PER_CLK bit positions are resolved per clock through that many lookup tables.
// Assumes TAPS is even when SYMMETRIC is set; in that mode only the low TAPS/2 coefficients are used.
module fir_da_top
    import fir_da_pkg::*;
#(
    parameter int TAPS         = 4,
    parameter int DATA_W       = 8,
    parameter int COEF_W       = 8,
    parameter int BITS_PER_CLK = 1,
    parameter int SYMMETRIC    = 0,
    parameter logic [TAPS*COEF_W-1:0] COEFS = 32'hFE07_FB03,
    localparam int OUT_W = out_w(DATA_W, COEF_W, TAPS, SYMMETRIC, BITS_PER_CLK)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_sample,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_result
);

    localparam int NA  = (SYMMETRIC != 0) ? TAPS / 2 : TAPS;
    localparam int PW  = pad_w(DATA_W, SYMMETRIC, BITS_PER_CLK);
    localparam int CPO = PW / BITS_PER_CLK;
    localparam int LW  = lut_w(COEF_W, NA);

    logic                            load;
    logic                            step;
    logic [BITS_PER_CLK-1:0][NA-1:0] dig;
    logic [BITS_PER_CLK*LW-1:0]      lut_bus;

    fir_da_line #(
        .TAPS(TAPS), .DW(DATA_W), .NA(NA), .PW(PW),
        .B(BITS_PER_CLK), .SYMM(SYMMETRIC)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .sample_i(in_sample), .dig_o(dig)
    );

    for (genvar j = 0; j < BITS_PER_CLK; j++) begin : g_rom
        fir_da_rom #(
            .TAPS(TAPS), .NA(NA), .CW(COEF_W), .LW(LW), .COEFS(COEFS)
        ) u_rom (
            .addr_i(dig[j]), .val_o(lut_bus[j*LW +: LW])
        );
    end

    fir_da_acc #(
        .B(BITS_PER_CLK), .LW(LW), .CPO(CPO), .OW(OUT_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .lut_i(lut_bus),
        .load_o(load), .step_o(step), .out_valid_o(out_valid),
        .out_result_o(out_result)
    );

endmodule

// File: tb/fir_da_top_tb_top.sv
// Bench: four configurations share one stimulus stream. A bench-side acceptance
// model and reference convolution score every result and its latency.
module fir_da_top_tb_top;
    import fir_da_pkg::*;

    localparam int OW0 = out_w(8, 8, 4, 0, 1);
    localparam int OW1 = out_w(8, 8, 4, 0, 8);
    localparam int OW2 = out_w(8, 8, 4, 1, 3);
    localparam int OW3 = out_w(8, 8, 4, 0, 3);
    localparam int NS  = 12;
    localparam int SAMPLES [NS] = '{5, -3, 127, -128, 0, 1, -1, 64, -86, 85, 100, -100};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_sample = '0;
    logic [3:0] ov;
    logic signed [OW0-1:0] res0;
    logic signed [OW1-1:0] res1;
    logic signed [OW2-1:0] res2;
    logic signed [OW3-1:0] res3;
    longint rv [4];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit after_rst = 1'b0;
    int cpo [4] = '{8, 1, 3, 3};
    int cf  [4][4] = '{'{3, -5, 7, -2}, '{3, -5, 7, -2}, '{3, -5, -5, 3}, '{3, -5, 7, -2}};
    int hist [4][4];
    longint ev [4][256];
    int ec [4][256];
    int wr [4];
    int rd [4];
    int rem [4];

    always #10 clk = ~clk;

    fir_da_top #(.BITS_PER_CLK(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ov[0]), .out_result(res0));
    fir_da_top #(.BITS_PER_CLK(8)) dut_par_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ov[1]), .out_result(res1));
    fir_da_top #(.BITS_PER_CLK(3), .SYMMETRIC(1)) dut_sym_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ov[2]), .out_result(res2));
    fir_da_top #(.BITS_PER_CLK(3)) dut_pad_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(ov[3]), .out_result(res3));

    always_comb begin
        rv[0] = longint'(res0);
        rv[1] = longint'(res1);
        rv[2] = longint'(res2);
        rv[3] = longint'(res3);
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: acceptance rule (R4, R5, R6) and convolution (R2, R8).
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                rem[i] = 0; wr[i] = 0; rd[i] = 0;
                for (int k = 0; k < 4; k++) hist[i][k] = 0;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (in_valid && rem[i] <= 1) begin
                    longint e;
                    for (int k = 3; k > 0; k--) hist[i][k] = hist[i][k-1];
                    hist[i][0] = int'($signed(in_sample));
                    e = 0;
                    for (int k = 0; k < 4; k++) e += longint'(cf[i][k]) * hist[i][k];
                    ev[i][wr[i] % 256] = e;
                    ec[i][wr[i] % 256] = cyc;
                    wr[i]++;
                    rem[i] = cpo[i];
                end else if (rem[i] > 0) begin
                    rem[i]--;
                end
            end
        end
    end

    // Scoreboard: value and latency of every result pulse.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 4; i++) begin
                if (ov[i]) begin
                    if (rd[i] >= wr[i]) begin
                        check(1'b0, "R4 unexpected out_valid", rv[i], 0);
                    end else begin
                        string tv;
                        tv = (i == 2) ? "R8 symmetric result" :
                             (i == 3) ? "R9 padded result" :
                             after_rst ? "R1 first result after reset" : "R2 R7 result";
                        check(rv[i] == ev[i][rd[i] % 256], tv, rv[i], ev[i][rd[i] % 256]);
                        check(cyc - ec[i][rd[i] % 256] == cpo[i], "R3 R6 latency",
                              cyc - ec[i][rd[i] % 256], cpo[i]);
                        rd[i]++;
                    end
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic drive(input bit v, input int s);
        @(negedge clk);
        in_valid = v;
        in_sample = s[7:0];
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        for (int i = 0; i < 4; i++) begin
            check(ov[i] == 1'b0, "R1 out_valid after reset", longint'(ov[i]), 0);
            check(rv[i] == 0, "R1 out_result after reset", rv[i], 0);
        end
        // Table walk: isolated samples, extremes included (R2, R7, R9)
        for (int n = 0; n < NS; n++) begin
            drive(1'b1, SAMPLES[n]);
            drive(1'b0, 0);
            repeat (9) drive(1'b0, 0);
        end
        // Held valid: final digit and next acceptance in the same cycle (R4)
        for (int n = 0; n < 40; n++) drive(1'b1, SAMPLES[(n * 5) % NS]);
        drive(1'b0, 0);
        repeat (12) drive(1'b0, 0);
        // Pulses while busy are ignored (R5)
        for (int n = 0; n < 30; n++) drive(n % 2 == 0, SAMPLES[(n * 7) % NS] ^ 32'h55);
        drive(1'b0, 0);
        repeat (12) drive(1'b0, 0);
        // Reset mid-computation, then a lone sample sees cleared taps (R1)
        drive(1'b1, -77);
        drive(1'b0, 0);
        drive(1'b0, 0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        after_rst = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            check(ov == 4'b0, "R1 no pulse after mid-run reset", longint'(ov), 0);
        end
        drive(1'b1, 50);
        drive(1'b0, 0);
        repeat (12) drive(1'b0, 0);
        after_rst = 1'b0;
        // Every accepted sample produced exactly one result (R4)
        for (int i = 0; i < 4; i++)
            check(rd[i] == wr[i], "R4 results match acceptances", rd[i], wr[i]);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule